// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block sits behind the receive pin of a LIN slave node. It watches an oversampled receive line and handles the whole frame header by itself, with no help from software. The header has four parts: a long dominant break, a recessive delimiter, a synchronisation byte of alternating bits, and a protected identifier whose top two bits are parity.

For each header that arrives intact, the block raises exactly one event and presents the 6-bit identifier. For each header that fails, it raises one error flag from six separate classes. A new break is recognised whatever the receiver is doing, and it restarts header processing.

The line is sampled once per clock. A bit lasts `div_in` clocks. When automatic resynchronisation is enabled, the block measures the sync field and retimes the identifier byte with the measured bit period. This lets a slave running from a loose internal oscillator follow the master. The measured period is also reported, so the host can adopt it. After a good header, a response-pass flag tells the downstream logic whether the bytes that follow should be forwarded. Muting suppresses that flag.

Top module: `lin_hdr_rx`

## Requirements
- R1: A low level held for at least 11×`div_in` consecutive clocks is a break. It is recognised in any state, including part-way through a byte, and it abandons that byte without raising any flag. A shorter low level outside a header changes nothing.
- R2: A delimiter that stays high for fewer than `div_in` clocks before the next falling edge raises error bit 0 (delimiter short). The header is then dropped.
- R3: The sync field must give five falling edges. Each gap between successive edges must lie between 1.5 and 2.5 bit periods, and the line must be low half a bit after the fifth edge. Otherwise error bit 1 (sync) is raised.
- R4: A low stop bit in the sync byte or in the identifier byte raises error bit 2 (framing). The flag is raised when the line returns high, unless a break is recognised first.
- R5: The identifier byte arrives LSB first. Bits 5:0 are the ID, bit 6 must equal ID0^ID1^ID2^ID4, and bit 7 must equal the inverse of ID1^ID3^ID4^ID5. A mismatch raises error bit 3 (parity).
- R6: With `autosync` high, the new bit period is the clock count from the first to the fifth sync falling edge, divided by 8. This period times the identifier byte and appears on `div_out`. With `autosync` low, `div_out` keeps `div_in`.
- R7: With `autosync` high, if |measured − `div_in`|×50 > 7×`div_in` (beyond ±14 %), error bit 4 (deviation) is raised. In that case no header is reported and `div_out` keeps `div_in`.
- R8: If the identifier byte has not completed 48×`div_in` clocks after the break began, error bit 5 (time-out) is raised.
- R9: A good header produces a single-cycle `hdr_valid` pulse, with the ID on `hdr_id`. `hdr_valid` never coincides with an error, `err` is at most one-hot, and each header yields exactly one event.
- R10: With each `hdr_valid`, `resp_pass` is loaded with the inverse of `mute`. It is cleared when the next break is recognised.
- R11: While `en` is low, the block stays idle: no event, no error, and `resp_pass` low.
- R12: After reset, `hdr_valid`, `err`, `resp_pass` and `div_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable |
| rx | input | 1 | Serial receive line, high is recessive |
| div_in | input | DW | Programmed bit period in clocks |
| autosync | input | 1 | Retime from the measured sync field |
| mute | input | 1 | Suppress forwarding of the response |
| hdr_valid | output | 1 | One-cycle pulse per good header |
| hdr_id | output | 6 | Identifier of the last good header |
| err | output | 6 | One-cycle error flags: delimiter, sync, framing, parity, deviation, time-out |
| resp_pass | output | 1 | Following response may be forwarded |
| div_out | output | DW | Bit period in use after the last sync |

## Verification
The header path is driven in several ways:
- Clean headers at the nominal rate, with break lengths both at the 11-bit limit and above it.
- Sync fields sent at rates inside and outside the ±14 % window. These separate a valid rebaud from a deviation fault, and from the plain sync-value fault that a misshaped byte such as 0x54 provokes.
- Deliberately corrupted headers, with a short delimiter, a low stop bit in each of the two bytes, a flipped parity bit, and a missing identifier byte. Each of these must map to its own flag.
- A break injected into a half-received identifier byte, and a 10-bit low pulse. Together these show the difference between a genuine break and a long run of zero bits.
- Runs with mute set and with the enable dropped, to show that only the forwarding flag and the event stream respond to those inputs.

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rx,
  input  logic [DW-1:0] div_in,
  input  logic          autosync,
  input  logic          mute,
  output logic          hdr_valid,
  output logic [5:0]    hdr_id,
  output logic [5:0]    err,
  output logic          resp_pass,
  output logic [DW-1:0] div_out
);
  localparam int TW = DW + 6;
  localparam int XW = TW + 6;
  localparam int BRK_BITS = 11;
  localparam int TO_BITS  = 48;

  typedef enum logic [2:0] {S_IDLE, S_BRK, S_DEL, S_SYNC, S_BYTE, S_WAIT, S_HOLD} st_t;
  st_t st;

  logic          rx_q, is_pid;
  logic [TW-1:0] lowcnt, ttim, mcnt, icnt;
  logic [DW-1:0] hcnt, tcnt, div_act;
  logic [2:0]    ecnt;
  logic [3:0]    bcnt;
  logic [7:0]    sh;

  logic          fall, brk_hit, dev, par_ok;
  logic [TW-1:0] brk_lim, to_lim, ilo, ihi, meas, m8, diff, dact_w;
  logic [DW-1:0] pb_new;

  assign fall    = rx_q & ~rx;
  assign brk_lim = TW'(div_in) * TW'(BRK_BITS);
  assign to_lim  = TW'(div_in) * TW'(TO_BITS);
  assign brk_hit = ~rx && (lowcnt == brk_lim - TW'(1));
  assign ilo     = (TW'(div_in) * TW'(3)) >> 1;
  assign ihi     = (TW'(div_in) * TW'(5)) >> 1;
  assign meas    = mcnt + TW'(1);
  assign m8      = meas >> 3;
  assign dact_w  = TW'(div_act);
  assign diff    = (m8 >= dact_w) ? m8 - dact_w : dact_w - m8;
  assign dev     = (XW'(diff) * XW'(50)) > (XW'(div_act) * XW'(7));
  assign pb_new  = autosync ? m8[DW-1:0] : div_act;
  assign par_ok  = (sh[6] == (sh[0] ^ sh[1] ^ sh[2] ^ sh[4])) &&
                   (sh[7] == ~(sh[1] ^ sh[3] ^ sh[4] ^ sh[5]));
  assign div_out = div_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rx_q <= 1'b1; is_pid <= 1'b0;
      lowcnt <= '0; ttim <= '0; mcnt <= '0; icnt <= '0;
      hcnt <= '0; tcnt <= '0; div_act <= '0;
      ecnt <= '0; bcnt <= '0; sh <= '0;
      hdr_valid <= 1'b0; hdr_id <= '0; err <= '0; resp_pass <= 1'b0;
    end else if (!en) begin
      st <= S_IDLE; rx_q <= 1'b1; lowcnt <= '0; ttim <= '0;
      hdr_valid <= 1'b0; err <= '0; resp_pass <= 1'b0;
    end else begin
      rx_q      <= rx;
      hdr_valid <= 1'b0;
      err       <= '0;
      if (rx) lowcnt <= '0;
      else if (lowcnt != brk_lim) lowcnt <= lowcnt + TW'(1);

      if (brk_hit) begin
        st <= S_BRK; ttim <= brk_lim; div_act <= div_in; resp_pass <= 1'b0;
      end else if (st != S_IDLE && ttim >= to_lim) begin
        err[5] <= 1'b1; st <= S_IDLE;
      end else begin
        if (st != S_IDLE) ttim <= ttim + TW'(1);
        case (st)
          S_BRK: if (rx) begin st <= S_DEL; hcnt <= DW'(1); end
          S_DEL: begin
            if (!rx) begin
              if (hcnt < div_in) begin err[0] <= 1'b1; st <= S_IDLE; end
              else begin st <= S_SYNC; mcnt <= '0; icnt <= '0; ecnt <= 3'd1; end
            end else if (hcnt != '1) hcnt <= hcnt + DW'(1);
          end
          S_SYNC: begin
            mcnt <= mcnt + TW'(1);
            if (fall) begin
              if (icnt + TW'(1) < ilo) begin err[1] <= 1'b1; st <= S_IDLE; end
              else if (ecnt == 3'd4) begin
                if (autosync && dev) begin err[4] <= 1'b1; st <= S_IDLE; end
                else begin
                  div_act <= pb_new; st <= S_BYTE; is_pid <= 1'b0;
                  bcnt <= 4'd8; tcnt <= (pb_new >> 1) - DW'(1);
                end
              end else begin ecnt <= ecnt + 3'd1; icnt <= '0; end
            end else if (rx && (icnt + TW'(1) > ihi)) begin
              err[1] <= 1'b1; st <= S_IDLE;
            end else if (icnt != '1) icnt <= icnt + TW'(1);
          end
          S_WAIT: if (fall) begin
            st <= S_BYTE; bcnt <= 4'd0; tcnt <= (div_act >> 1) - DW'(1);
          end
          S_BYTE: begin
            if (tcnt != '0) tcnt <= tcnt - DW'(1);
            else begin
              tcnt <= div_act - DW'(1);
              if (bcnt == 4'd0) begin
                if (rx) st <= S_WAIT; else bcnt <= 4'd1;
              end else if (bcnt == 4'd9) begin
                if (!rx) st <= S_HOLD;
                else if (!is_pid) begin st <= S_WAIT; is_pid <= 1'b1; end
                else if (!par_ok) begin err[3] <= 1'b1; st <= S_IDLE; end
                else begin
                  hdr_valid <= 1'b1; hdr_id <= sh[5:0];
                  resp_pass <= ~mute; st <= S_IDLE;
                end
              end else if (is_pid) begin
                sh <= {rx, sh[7:1]}; bcnt <= bcnt + 4'd1;
              end else begin
                if (rx) begin err[1] <= 1'b1; st <= S_IDLE; end
                else bcnt <= 4'd9;
              end
            end
          end
          S_HOLD: if (rx) begin err[2] <= 1'b1; st <= S_IDLE; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_hdr_rx_chk.sv
module lin_hdr_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       rx,
  input logic       mute,
  input logic       hdr_valid,
  input logic [5:0] err,
  input logic       resp_pass
);
  // R9
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(err));
  // R9
  hdr_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hdr_valid && (err != 6'd0)));
  // R9
  hdr_single_chk: assert property (@(posedge clk) disable iff (!rst_n) hdr_valid |=> !hdr_valid);
  // R10
  mute_pass_chk: assert property (@(posedge clk) disable iff (!rst_n) hdr_valid |-> (resp_pass == !$past(mute)));
  // R11
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!hdr_valid && err == 6'd0 && !resp_pass));
  // R5
  hdr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) hdr_valid |-> $past(rx));
  // R2
  delim_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) err[0] |-> !$past(rx));
  // R4
  frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) err[2] |-> $past(rx));
endmodule

bind lin_hdr_rx lin_hdr_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rx(rx), .mute(mute),
  .hdr_valid(hdr_valid), .err(err), .resp_pass(resp_pass)
);

// File: tb/sim_lin_hdr_rx.sv
module sim_lin_hdr_rx;
  localparam int CLK_NS = 10;
  localparam int DW = 12;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, rx = 1'b1, autosync = 1'b0, mute = 1'b0;
  logic [DW-1:0] div_in = DW'(D);
  logic hdr_valid, resp_pass;
  logic [5:0] hdr_id, err;
  logic [DW-1:0] div_out;

  lin_hdr_rx #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .rx(rx), .div_in(div_in),
    .autosync(autosync), .mute(mute), .hdr_valid(hdr_valid), .hdr_id(hdr_id),
    .err(err), .resp_pass(resp_pass), .div_out(div_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0, nev = 0, nexp = 0;
  bit done = 1'b0;

  typedef struct {
    logic hdr; logic [5:0] id; logic [5:0] ecode; logic resp; logic [DW-1:0] div; string tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push_hdr(logic [5:0] id, logic resp, int dv, string tag);
    exp_t e;
    e.hdr = 1'b1; e.id = id; e.ecode = '0; e.resp = resp; e.div = DW'(dv); e.tag = tag;
    q.push_back(e); nexp++;
  endtask

  task automatic push_err(logic [5:0] code, string tag);
    exp_t e;
    e.hdr = 1'b0; e.id = '0; e.ecode = code; e.resp = 1'b0; e.div = '0; e.tag = tag;
    q.push_back(e); nexp++;
  endtask

  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n && (hdr_valid || err != 6'd0)) begin
      nev++;
      if (q.size() == 0) chk(1'b0, "R9", "unexpected event", int'({hdr_valid, err}), 0);
      else begin
        e = q.pop_front();
        if (e.hdr) begin
          chk(hdr_valid == 1'b1, e.tag, "hdr_valid", int'(hdr_valid), 1);
          chk(hdr_id == e.id, e.tag, "hdr_id", int'(hdr_id), int'(e.id));
          chk(resp_pass == e.resp, e.tag, "resp_pass", int'(resp_pass), int'(e.resp));
          chk(div_out == e.div, e.tag, "div_out", int'(div_out), int'(e.div));
        end else begin
          chk(err == e.ecode && !hdr_valid, e.tag, "err", int'(err), int'(e.ecode));
        end
      end
    end
  end

  function automatic logic [7:0] pid_of(logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  task automatic hold(logic v, int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b, int per, logic stopv = 1'b1);
    hold(1'b0, per);
    for (int i = 0; i < 8; i++) hold(b[i], per);
    hold(stopv, per);
  endtask

  task automatic header(logic [7:0] pid, int brk_bits = 13, int sper = D, int pper = D);
    hold(1'b0, brk_bits * D);
    hold(1'b1, D);
    send_byte(8'h55, sper);
    send_byte(pid, pper);
    hold(1'b1, 3 * D);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    chk(1'b0, "WATCHDOG", "run did not end", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!hdr_valid, "R12", "hdr_valid", int'(hdr_valid), 0);
    chk(err == 6'd0, "R12", "err", int'(err), 0);
    chk(!resp_pass, "R12", "resp_pass", int'(resp_pass), 0);
    chk(div_out == '0, "R12", "div_out", int'(div_out), 0);
    rst_n = 1'b1; en = 1'b1;
    hold(1'b1, 4 * D);

    // R9 R10 plain header, not muted
    push_hdr(6'h3C, 1'b1, D, "R9");
    header(pid_of(6'h3C));

    // R1 a 10-bit low run is not a break: resp_pass untouched
    hold(1'b0, 10 * D); hold(1'b1, 3 * D);
    chk(resp_pass == 1'b1, "R1", "resp_pass after short low", int'(resp_pass), 1);

    // R2 short delimiter; R10 break clears resp_pass
    push_err(6'h01, "R2");
    hold(1'b0, 13 * D); hold(1'b1, D - 1);
    send_byte(8'h55, D); send_byte(pid_of(6'h01), D); hold(1'b1, 3 * D);
    chk(resp_pass == 1'b0, "R10", "resp_pass after break", int'(resp_pass), 0);

    // R10 muted header
    mute = 1'b1;
    push_hdr(6'h00, 1'b0, D, "R10");
    header(pid_of(6'h00));
    mute = 1'b0;

    // R1 break of exactly 11 bits
    push_hdr(6'h3F, 1'b1, D, "R1");
    header(pid_of(6'h3F), 11);

    // R3 wrong sync byte
    push_err(6'h02, "R3");
    hold(1'b0, 13 * D); hold(1'b1, D);
    send_byte(8'h54, D); send_byte(pid_of(6'h02), D); hold(1'b1, 3 * D);

    // R4 low stop bit in the sync byte
    push_err(6'h04, "R4");
    hold(1'b0, 13 * D); hold(1'b1, D);
    send_byte(8'h55, D, 1'b0); hold(1'b1, 12 * D);

    // R4 low stop bit in the identifier byte
    push_err(6'h04, "R4");
    hold(1'b0, 13 * D); hold(1'b1, D);
    send_byte(8'h55, D); send_byte(pid_of(6'h05), D, 1'b0); hold(1'b1, 3 * D);

    // R5 flipped parity bit 7
    push_err(6'h08, "R5");
    header(pid_of(6'h12) ^ 8'h80);

    // R8 identifier never arrives
    push_err(6'h20, "R8");
    hold(1'b0, 13 * D); hold(1'b1, D);
    send_byte(8'h55, D); hold(1'b1, 30 * D);

    // R6 resync to a slower and a faster master
    autosync = 1'b1;
    push_hdr(6'h2A, 1'b1, 18, "R6");
    header(pid_of(6'h2A), 13, 18, 18);
    push_hdr(6'h15, 1'b1, 14, "R6");
    header(pid_of(6'h15), 13, 14, 14);

    // R7 sync 19 clocks per bit is beyond 14 percent
    push_err(6'h10, "R7");
    hold(1'b0, 13 * D); hold(1'b1, D);
    send_byte(8'h55, 19); hold(1'b1, 3 * D);
    chk(div_out == DW'(D), "R7", "div_out after deviation", int'(div_out), D);
    autosync = 1'b0;

    // R1 break lands inside the identifier byte
    push_hdr(6'h07, 1'b1, D, "R1");
    hold(1'b0, 13 * D); hold(1'b1, D);
    send_byte(8'h55, D);
    hold(1'b0, D); hold(1'b1, 2 * D);
    header(pid_of(6'h07));

    // R11 disabled receiver
    en = 1'b0;
    hold(1'b1, 2);
    chk(resp_pass == 1'b0, "R11", "resp_pass when disabled", int'(resp_pass), 0);
    header(pid_of(6'h09));
    chk(nev == nexp, "R11", "events while disabled", nev, nexp);
    en = 1'b1;
    hold(1'b1, 4 * D);

    chk(q.size() == 0, "R9", "missing events", q.size(), 0);
    chk(nev == nexp, "R9", "event count", nev, nexp);
    finish_up();
  end
endmodule